// File: doc/BRIEF.md
# Trimmable Real-Time Calendar Counter

This block keeps time of day (seconds, minutes, hours) and a running day count, advanced by a fixed-rate input tick. The tick rate per second is a parameter, so a fast tick can stand in for a slow oscillator. An 8-bit trim value slows the timebase. For every `PPM_WINDOW` input ticks, exactly `trim` ticks are discarded. The discards are spaced evenly by an accumulator, so they do not bunch up at the start of the window. With the default window of one million, one trim step equals one part per million. A trim of 12 corresponds to roughly one second per day.

The host uses a plain register write port and a read strobe. The read strobe copies all time fields into a shadow set in one cycle, so a second rollover cannot split a read. Writes to the time fields and the trim value are gated by write protection. Protection is lifted only by writing the unlock code to the control address. A cold-start flag, raised by reset, tells software that the time is not valid yet. It stays up until software clears it. None of the interfaces carries a data stream, so all pins are plain control and status with no back-pressure.

Top module: `rtc_trim_core`

## Requirements
- R1: After reset the time is 00:00:00 on day 0 and the shadow outputs read zero. The trim value is 186, write protection is on (`wp_on`=1), `cold_flag`=1 and `sec_strobe`=0.
- R2: On an input tick, the block forms `acc + trim`. If the result is `>= PPM_WINDOW`, the tick is dropped and `acc` becomes the sum minus `PPM_WINDOW`. Otherwise the tick is kept and `acc` becomes the sum. `acc` starts at 0 after reset. As a result, every `PPM_WINDOW` ticks drop exactly `trim` ticks, and a larger trim yields fewer seconds.
- R3: `sec_strobe` is high for one cycle. It is raised in the cycle after the edge that sees the `TICKS_PER_SEC`-th kept tick since the last second.
- R4: When a cycle has `sec_strobe`=1 and no accepted time write, the clock advances by one second. Seconds and minutes wrap from 59 to 0 and hours from 23 to 0, each wrap carrying into the next field. The 16-bit day counter wraps from 65535 to 0. All fields change on the same edge.
- R5: `rd_en`=1 at an edge copies the live time (its value before that edge's update) into `rd_sec`/`rd_min`/`rd_hr`/`rd_day`. The copy is visible after the edge and holds until the next `rd_en`.
- R6: A write of 0xA5 (low 8 bits of `wr_data`) to address 0 clears write protection. A write of any other value to address 0 sets it again. While protection is on, writes to addresses 1 to 5 change nothing.
- R7: The address map is 1 = seconds (accepted if below 60), 2 = minutes (below 60), 3 = hours (below 24), 4 = day (all 16 bits) and 5 = trim (low 8 bits, visible on `trim_val` after the edge). A time write with an out-of-range `wr_data` value is dropped.
- R8: An accepted time write takes effect at its edge. That edge then does no one-second increment, even if `sec_strobe` is high.
- R9: Any write to address 6 clears `cold_flag`, whatever the protection state. Only reset sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high (power-up / power loss) |
| tick_in | input | 1 | One-cycle timebase tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Latch live time into the shadow outputs |
| rd_sec | output | 6 | Shadow seconds |
| rd_min | output | 6 | Shadow minutes |
| rd_hr | output | 5 | Shadow hours |
| rd_day | output | 16 | Shadow day count |
| trim_val | output | 8 | Current trim value |
| wp_on | output | 1 | Write protection active |
| cold_flag | output | 1 | Time invalid since reset |
| sec_strobe | output | 1 | One-cycle pulse per second |

## Verification
A wrong accumulator or prescaler state shows up as a `sec_strobe` that comes early or late. The bench compares the strobe against its model on every cycle, so such an error is reported within one second of ticks. For the trim drop, the error shows within a few trim-spaced drops. A wrong counter or carry is invisible until the next read strobe copies the time out. For that reason the bench issues reads often, and it reads directly after each rollover it forces. Protection and cold-flag errors show on `trim_val`, `wp_on` and `cold_flag` in the cycle after the offending write.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_SEC  = 3'd1,
    A_MIN  = 3'd2,
    A_HR   = 3'd3,
    A_DAY  = 3'd4,
    A_TRIM = 3'd5,
    A_COLD = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [15:0] day;
    logic [4:0]  hr;
    logic [5:0]  min;
    logic [5:0]  sec;
  } rtc_time_t;

  localparam logic [7:0] UNLOCK_CODE = 8'hA5;
  localparam logic [7:0] TRIM_INIT   = 8'd186;
endpackage

// File: rtl/rtc_tick_drop.sv
module rtc_tick_drop #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int PPM_WINDOW    = 1000000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_in,
  input  logic [7:0] trim,
  output logic       sec_strobe
);
  localparam int AW = $clog2(PPM_WINDOW + 256);
  localparam int PW = $clog2(TICKS_PER_SEC);
  localparam logic [AW:0]   WIN     = (AW+1)'(PPM_WINDOW);
  localparam logic [PW-1:0] PRE_MAX = PW'(TICKS_PER_SEC - 1);

  logic [AW-1:0] acc;
  logic [PW-1:0] pre;
  logic [AW:0]   sum;
  logic          drop;

  assign sum  = {1'b0, acc} + {{(AW-7){1'b0}}, trim};
  assign drop = (sum >= WIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      pre        <= '0;
      sec_strobe <= 1'b0;
    end else begin
      sec_strobe <= 1'b0;
      if (tick_in) begin
        if (drop) begin
          acc <= AW'(sum - WIN);
        end else begin
          acc <= AW'(sum);
          if (pre == PRE_MAX) begin
            pre        <= '0;
            sec_strobe <= 1'b1;
          end else begin
            pre <= pre + 1'b1;
          end
        end
      end
    end
  end

  assert_acc_range_R2: assert property (@(posedge clk) disable iff (rst)
    {1'b0, acc} < WIN);
  assert_drop_holds_pre_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_in && drop) |=> $stable(pre) && !sec_strobe);
  assert_pre_range_R3: assert property (@(posedge clk) disable iff (rst)
    pre <= PRE_MAX);
  assert_strobe_tick_R3: assert property (@(posedge clk) disable iff (rst)
    sec_strobe |-> $past(tick_in));
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_trim_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sec_strobe,
  input  logic        ld_en,
  input  reg_addr_e   ld_sel,
  input  logic [15:0] ld_val,
  output rtc_time_t   now
);
  always_ff @(posedge clk) begin
    if (rst) begin
      now <= '0;
    end else if (ld_en) begin
      case (ld_sel)
        A_SEC:   now.sec <= ld_val[5:0];
        A_MIN:   now.min <= ld_val[5:0];
        A_HR:    now.hr  <= ld_val[4:0];
        A_DAY:   now.day <= ld_val;
        default: ;
      endcase
    end else if (sec_strobe) begin
      if (now.sec == 6'd59) begin
        now.sec <= '0;
        if (now.min == 6'd59) begin
          now.min <= '0;
          if (now.hr == 5'd23) begin
            now.hr  <= '0;
            now.day <= now.day + 16'd1;
          end else begin
            now.hr <= now.hr + 5'd1;
          end
        end else begin
          now.min <= now.min + 6'd1;
        end
      end else begin
        now.sec <= now.sec + 6'd1;
      end
    end
  end

  assert_field_range_R4: assert property (@(posedge clk) disable iff (rst)
    now.sec < 6'd60 && now.min < 6'd60 && now.hr < 5'd24);
  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (sec_strobe && !ld_en && now.sec == 6'd59) |=> now.sec == 6'd0);
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_sel == A_SEC) |=> now.sec == $past(ld_val[5:0]));
endmodule

// File: rtl/rtc_trim_core.sv
module rtc_trim_core
  import rtc_trim_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int PPM_WINDOW    = 1000000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_in,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  output logic [5:0]  rd_sec,
  output logic [5:0]  rd_min,
  output logic [4:0]  rd_hr,
  output logic [15:0] rd_day,
  output logic [7:0]  trim_val,
  output logic        wp_on,
  output logic        cold_flag,
  output logic        sec_strobe
);
  reg_addr_e addr;
  rtc_time_t now, shadow;
  logic      wr_ok, in_range, ld_en;

  assign addr  = reg_addr_e'(wr_addr);
  assign wr_ok = wr_en && !wp_on;

  always_comb begin
    case (addr)
      A_SEC, A_MIN: in_range = (wr_data < 16'd60);
      A_HR:         in_range = (wr_data < 16'd24);
      A_DAY:        in_range = 1'b1;
      default:      in_range = 1'b0;
    endcase
  end
  assign ld_en = wr_ok && in_range;

  rtc_tick_drop #(.TICKS_PER_SEC(TICKS_PER_SEC), .PPM_WINDOW(PPM_WINDOW)) u_drop (
    .clk(clk), .rst(rst), .tick_in(tick_in), .trim(trim_val), .sec_strobe(sec_strobe));

  rtc_time_chain u_chain (
    .clk(clk), .rst(rst), .sec_strobe(sec_strobe), .ld_en(ld_en),
    .ld_sel(addr), .ld_val(wr_data), .now(now));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow    <= '0;
      trim_val  <= TRIM_INIT;
      wp_on     <= 1'b1;
      cold_flag <= 1'b1;
    end else begin
      if (rd_en) shadow <= now;
      if (wr_ok && addr == A_TRIM) trim_val <= wr_data[7:0];
      if (wr_en && addr == A_CTRL) wp_on <= (wr_data[7:0] != UNLOCK_CODE);
      if (wr_en && addr == A_COLD) cold_flag <= 1'b0;
    end
  end

  assign rd_sec = shadow.sec;
  assign rd_min = shadow.min;
  assign rd_hr  = shadow.hr;
  assign rd_day = shadow.day;

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(shadow));
  assert_locked_trim_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wp_on && addr == A_TRIM) |=> $stable(trim_val));
  assert_locked_time_R6: assert property (@(posedge clk) disable iff (rst)
    wp_on |-> !ld_en);
  assert_cold_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !cold_flag |=> !cold_flag);
endmodule

// File: tb/test_rtc_trim_core.sv
module test_rtc_trim_core;
  localparam int TPS = 4;
  localparam int WIN = 300;

  logic clk = 0, rst = 1, tick_in = 0, wr_en = 0, rd_en = 0;
  logic [2:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [5:0] rd_sec, rd_min;
  logic [4:0] rd_hr;
  logic [15:0] rd_day;
  logic [7:0] trim_val;
  logic wp_on, cold_flag, sec_strobe;

  int n_checks = 0, n_fail = 0;
  int tick_mode = 0;
  bit model_on = 0;

  // behavioural reference state
  int m_acc, m_pre, m_trim, m_sec, m_min, m_hr, m_day;
  int s_sec, s_min, s_hr, s_day;
  bit m_strobe, m_wp, m_cold;

  rtc_trim_core #(.TICKS_PER_SEC(TPS), .PPM_WINDOW(WIN)) i_rtc_trim_core (
    .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sec(rd_sec), .rd_min(rd_min),
    .rd_hr(rd_hr), .rd_day(rd_day), .trim_val(trim_val), .wp_on(wp_on),
    .cold_flag(cold_flag), .sec_strobe(sec_strobe));

  always #5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_pre = 0; m_strobe = 0; m_trim = 186; m_wp = 1; m_cold = 1;
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 0;
      s_sec = 0; s_min = 0; s_hr = 0; s_day = 0;
    end else begin
      bit nstrobe, ok, ld;
      int lim;
      nstrobe = 0;
      if (tick_in) begin
        if (m_acc + m_trim >= WIN) m_acc = m_acc + m_trim - WIN;
        else begin
          m_acc = m_acc + m_trim;
          if (m_pre == TPS - 1) begin m_pre = 0; nstrobe = 1; end
          else m_pre++;
        end
      end
      if (rd_en) begin s_sec = m_sec; s_min = m_min; s_hr = m_hr; s_day = m_day; end
      ok = wr_en && !m_wp;
      lim = (wr_addr == 1 || wr_addr == 2) ? 60 : (wr_addr == 3) ? 24 : 65536;
      ld = ok && wr_addr >= 1 && wr_addr <= 4 && int'(wr_data) < lim;
      if (ld) begin
        case (wr_addr)
          1: m_sec = wr_data; 2: m_min = wr_data;
          3: m_hr = wr_data;  default: m_day = wr_data;
        endcase
      end else if (m_strobe) begin
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin m_hr = 0; m_day = (m_day + 1) % 65536; end
          end
        end
      end
      if (ok && wr_addr == 5) m_trim = wr_data[7:0];
      if (wr_en && wr_addr == 0) m_wp = (wr_data[7:0] != 8'hA5);
      if (wr_en && wr_addr == 6) m_cold = 0;
      m_strobe = nstrobe;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R3 sec_strobe", sec_strobe, m_strobe);
      check("R5 rd_sec", rd_sec, s_sec);
      check("R5 rd_min", rd_min, s_min);
      check("R5 rd_hr", rd_hr, s_hr);
      check("R5 rd_day", rd_day, s_day);
      check("R7 trim_val", trim_val, m_trim);
      check("R6 wp_on", wp_on, m_wp);
      check("R9 cold_flag", cold_flag, m_cold);
    end
    case (tick_mode)
      0: tick_in <= 0;
      1: tick_in <= 1;
      default: tick_in <= ($urandom % 3) != 0;
    endcase
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en <= 1; wr_addr <= 3'(a); wr_data <= 16'(d);
    @(negedge clk);
    wr_en <= 0;
  endtask

  task automatic rd();
    @(negedge clk);
    rd_en <= 1;
    @(negedge clk);
    rd_en <= 0;
  endtask

  task automatic set_time(int h, int m, int s, int d);
    wr(3, h); wr(2, m); wr(1, s); wr(4, d);
  endtask

  initial begin
    #2000000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int strobes;
    repeat (3) @(negedge clk);
    rst <= 0;
    @(negedge clk);
    // R1 reset state
    check("R1 trim", trim_val, 186);
    check("R1 wp", wp_on, 1);
    check("R1 cold", cold_flag, 1);
    check("R1 rd_sec", rd_sec, 0);
    check("R1 strobe", sec_strobe, 0);
    model_on = 1;

    // R6 locked writes ignored
    wr(5, 7); wr(1, 30); rd();
    check("R6 locked trim", trim_val, 186);
    check("R6 locked sec", rd_sec, 0);
    // R9 cold cleared while protected
    wr(6, 0);
    check("R9 cleared", cold_flag, 0);

    wr(0, 'hA5);
    check("R6 unlocked", wp_on, 0);
    wr(5, 0);
    check("R7 trim write", trim_val, 0);

    // R3 four kept ticks per second, trim 0
    tick_mode = 1;
    strobes = 0;
    repeat (40) begin @(negedge clk); strobes += sec_strobe; end
    check("R3 strobes in 40 ticks", strobes, 10);

    // R4 full rollover including day wrap
    tick_mode = 0; idle(3);
    set_time(23, 59, 59, 65535);
    rd();
    check("R7 hr set", rd_hr, 23);
    check("R7 day set", rd_day, 65535);
    tick_mode = 1; idle(6); tick_mode = 0; idle(2); rd();
    check("R4 hr wrap", rd_hr, 0);
    check("R4 day wrap", rd_day, 0);
    check("R4 sec after", rd_sec, 0);

    // R7 out-of-range writes dropped
    wr(1, 60); wr(3, 24); wr(2, 64); rd();
    check("R7 sec range", rd_sec, 0);
    check("R7 hr range", rd_hr, 0);
    check("R7 min range", rd_min, 0);

    // R2 trim drops: trim 100 of 300 ticks
    wr(5, 100);
    tick_mode = 1; strobes = 0;
    repeat (600) begin @(negedge clk); strobes += sec_strobe; end
    check("R2 strobes with trim 100", strobes >= 99 && strobes <= 101, 1);

    // R8 mixed: random ticks with frequent writes and reads
    tick_mode = 2;
    for (int i = 0; i < 300; i++) begin
      wr(1, i % 70);
      rd();
      idle(i % 5);
    end
    wr(5, 255);
    for (int i = 0; i < 200; i++) begin
      wr($urandom % 7 == 0 ? 0 : 1 + $urandom % 5, $urandom % 300);
      if ($urandom % 4 == 0) wr(0, 'hA5);
      rd();
    end
    tick_mode = 0; idle(4);

    // R1 reset again restores flag
    rst <= 1; model_on = 0; idle(2); rst <= 0; @(negedge clk);
    check("R1 cold again", cold_flag, 1);
    check("R1 wp again", wp_on, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule